// File: doc/BRIEF.md
# Supply and Thermal Fault Supervisor

This block sits between the analog supervision comparators of a motor bridge controller and the digital logic that drives the gates. It takes the raw fault flags (battery overvoltage, battery undervoltage, power-rail undervoltage, bridge short, charge pump health, thermal warning, thermal shutdown and thermal release), filters each one against glitches, and turns them into a single bridge enable, three diagnostic pins and the shutdown requests for the regulator, the gate drivers, the serial line driver and the charge pump.

Each comparator with hysteresis is presented as two flags: one that asserts above the upper threshold and one that asserts below the lower threshold. The thermal shutdown is held from the moment the hot flag is seen until the cool flag arrives. A diagnostic latch keeps the thermal event visible until the host proves it is alive again with an accepted watchdog trigger.

Top module: `fault_supervisor`

## Requirements
- R1: Every fault flag acts only after it has held a new value for DEB_LEN (default 4) consecutive clock samples; a change that lasts fewer samples has no effect on any output.
- R2: `bridgeEn` is 1 only when a watchdog trigger has been accepted since reset or since the last thermal shutdown, and no short, no power-rail undervoltage, no battery overvoltage, no battery undervoltage and no thermal shutdown is present.
- R3: Battery overvoltage, battery undervoltage or charge pump failure (`cpOk`=0) drives `diag1`=0 and `diag2`=1, regardless of any other fault.
- R4: A short with no R3 fault drives `diag1`=1, `diag2`=0, whether or not power-rail undervoltage is present.
- R5: Power-rail undervoltage with no R3 or R4 fault drives `diag1`=1, `diag2`=1; with no such fault both are 0.
- R6: A thermal warning sets `diag3` to 1 and leaves `bridgeEn` and the shutdown requests unchanged.
- R7: A thermal shutdown raises `regOff`, `drvOff`, `serOff` and `resetReq` and drops `bridgeEn` one cycle after the filtered hot flag, and clears the accepted-trigger state.
- R8: The shutdown ends only when the filtered cool flag is 1 and the hot flag is 0; removing the hot flag alone keeps it.
- R9: A thermal shutdown sets `diag3` and keeps it 1 until the first `wdAccept` pulse after the shutdown has ended; pulses during the shutdown are ignored.
- R10: `cpOff` is 1 exactly while filtered battery overvoltage is present.
- R11: After reset all outputs are 0 and `bridgeEn` stays 0 until the first `wdAccept`.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rstN | input | 1 | Active-low asynchronous reset |
| wdAccept | input | 1 | One-cycle pulse: a watchdog trigger was accepted |
| pbatOv | input | 1 | Battery overvoltage flag |
| vbatUv | input | 1 | Battery undervoltage flag |
| pbatUv | input | 1 | Power-rail undervoltage flag |
| shortDet | input | 1 | Bridge short detected |
| cpOk | input | 1 | Charge pump healthy (0 is a fault) |
| tempWarn | input | 1 | Junction above warning level |
| tempHot | input | 1 | Junction above shutdown level |
| tempCool | input | 1 | Junction below release level |
| bridgeEn | output | 1 | Bridge drive enable |
| diag1 | output | 1 | Diagnostic pin 1 |
| diag2 | output | 1 | Diagnostic pin 2 |
| diag3 | output | 1 | Diagnostic pin 3 (thermal) |
| cpOff | output | 1 | Charge pump disable |
| regOff | output | 1 | Regulator shutdown request |
| drvOff | output | 1 | Gate driver shutdown request |
| serOff | output | 1 | Serial line driver shutdown request |
| resetReq | output | 1 | Host reset request |

## Verification
The diagnostic encoding is driven with single faults and with overlapping pairs (short with rail undervoltage, short with charge pump failure), which separates a correct priority order from one that merely decodes each fault alone. A flag pulse one sample shorter than the filter length and one of exactly its length tell a working debounce from one that is off by a cycle. The thermal sequence removes the hot flag before raising the cool flag and sends a watchdog pulse during shutdown, which distinguishes real hysteresis and a correctly gated diagnostic latch from a plain follower of the hot input.

// File: rtl/supv_pkg.sv
package supv_pkg;
  localparam int NUM_FLAGS = 8;
  localparam int IDX_OV    = 0;  // battery overvoltage
  localparam int IDX_UV    = 1;  // battery undervoltage
  localparam int IDX_RAILUV= 2;  // power-rail undervoltage
  localparam int IDX_SHORT = 3;  // bridge short
  localparam int IDX_CPF   = 4;  // charge pump failure (inverted health)
  localparam int IDX_WARN  = 5;  // thermal warning
  localparam int IDX_HOT   = 6;  // thermal shutdown level
  localparam int IDX_COOL  = 7;  // thermal release level

  typedef struct packed {
    logic armed;       // trigger accepted since reset / last shutdown
    logic shutdown;    // thermal shutdown in force
    logic thermLatch;  // thermal event pending host acknowledge
  } ctrl_strobes_t;
endpackage

// File: rtl/supv_datapath.sv
module supv_datapath
  import supv_pkg::*;
#(
  parameter int DEB_LEN = 4
) (
  input  logic                 clk,
  input  logic                 rstN,
  input  logic [NUM_FLAGS-1:0] rawFlags,
  input  ctrl_strobes_t        strobes,
  output logic [NUM_FLAGS-1:0] filtFlags,
  output logic                 bridgeEn,
  output logic                 diag1,
  output logic                 diag2,
  output logic                 diag3,
  output logic                 cpOff,
  output logic                 regOff,
  output logic                 drvOff,
  output logic                 serOff,
  output logic                 resetReq
);
  localparam int CNT_W = $clog2(DEB_LEN + 1);
  localparam logic [CNT_W-1:0] CNT_LAST = CNT_W'(DEB_LEN - 1);

  for (genvar g = 0; g < NUM_FLAGS; g++) begin : gDeb
    logic [CNT_W-1:0] runCnt;
    always_ff @(posedge clk or negedge rstN) begin
      if (!rstN) begin
        runCnt       <= '0;
        filtFlags[g] <= 1'b0;
      end else if (rawFlags[g] != filtFlags[g]) begin
        if (runCnt == CNT_LAST) begin
          filtFlags[g] <= rawFlags[g];
          runCnt       <= '0;
        end else begin
          runCnt <= runCnt + 1'b1;
        end
      end else begin
        runCnt <= '0;
      end
    end

    // a filtered flag may only move to a value the raw input already had
    assert_filter_follows_raw_R1 : assert property (@(posedge clk) disable iff (!rstN)
      !$stable(filtFlags[g]) |-> ($past(rawFlags[g]) == filtFlags[g]));
  end

  logic supplyFault;
  assign supplyFault = filtFlags[IDX_OV] | filtFlags[IDX_UV] | filtFlags[IDX_CPF];

  always_comb begin
    if (supplyFault)               {diag1, diag2} = 2'b01;
    else if (filtFlags[IDX_SHORT]) {diag1, diag2} = 2'b10;
    else if (filtFlags[IDX_RAILUV]){diag1, diag2} = 2'b11;
    else                           {diag1, diag2} = 2'b00;
  end

  assign bridgeEn = strobes.armed & ~strobes.shutdown & ~filtFlags[IDX_SHORT] &
                    ~filtFlags[IDX_RAILUV] & ~filtFlags[IDX_OV] & ~filtFlags[IDX_UV];
  assign diag3    = filtFlags[IDX_WARN] | strobes.thermLatch;
  assign cpOff    = filtFlags[IDX_OV];
  assign regOff   = strobes.shutdown;
  assign drvOff   = strobes.shutdown;
  assign serOff   = strobes.shutdown;
  assign resetReq = strobes.shutdown;

  assert_enable_blocked_by_fault_R2 : assert property (@(posedge clk) disable iff (!rstN)
    (filtFlags[IDX_SHORT] | filtFlags[IDX_RAILUV] | filtFlags[IDX_OV] | filtFlags[IDX_UV])
    |-> !bridgeEn);
  assert_supply_code_R3 : assert property (@(posedge clk) disable iff (!rstN)
    (filtFlags[IDX_OV] | filtFlags[IDX_UV] | filtFlags[IDX_CPF]) |-> (!diag1 && diag2));
  assert_short_code_R4 : assert property (@(posedge clk) disable iff (!rstN)
    (filtFlags[IDX_SHORT] && !diag2) |-> diag1);
  assert_shutdown_outputs_R7 : assert property (@(posedge clk) disable iff (!rstN)
    strobes.shutdown |-> (resetReq && !bridgeEn));
endmodule

// File: rtl/supv_control.sv
module supv_control
  import supv_pkg::*;
(
  input  logic          clk,
  input  logic          rstN,
  input  logic          wdAccept,
  input  logic          hotFilt,
  input  logic          coolFilt,
  output ctrl_strobes_t strobes
);
  logic armedQ, shutQ, latchQ;

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      armedQ <= 1'b0;
      shutQ  <= 1'b0;
      latchQ <= 1'b0;
    end else begin
      if (hotFilt)       shutQ <= 1'b1;
      else if (coolFilt) shutQ <= 1'b0;

      if (hotFilt)                   armedQ <= 1'b0;
      else if (wdAccept && !shutQ)   armedQ <= 1'b1;

      if (hotFilt)                   latchQ <= 1'b1;
      else if (wdAccept && !shutQ)   latchQ <= 1'b0;
    end
  end

  assign strobes = '{armed: armedQ, shutdown: shutQ, thermLatch: latchQ};

  assert_hot_enters_shutdown_R7 : assert property (@(posedge clk) disable iff (!rstN)
    hotFilt |=> (shutQ && !armedQ));
  assert_no_release_without_cool_R8 : assert property (@(posedge clk) disable iff (!rstN)
    (shutQ && !coolFilt) |=> shutQ);
  assert_latch_kept_in_shutdown_R9 : assert property (@(posedge clk) disable iff (!rstN)
    (latchQ && shutQ) |=> latchQ);
endmodule

// File: rtl/fault_supervisor.sv
module fault_supervisor
  import supv_pkg::*;
#(
  parameter int DEB_LEN = 4
) (
  input  logic clk,
  input  logic rstN,
  input  logic wdAccept,
  input  logic pbatOv,
  input  logic vbatUv,
  input  logic pbatUv,
  input  logic shortDet,
  input  logic cpOk,
  input  logic tempWarn,
  input  logic tempHot,
  input  logic tempCool,
  output logic bridgeEn,
  output logic diag1,
  output logic diag2,
  output logic diag3,
  output logic cpOff,
  output logic regOff,
  output logic drvOff,
  output logic serOff,
  output logic resetReq
);
  logic [NUM_FLAGS-1:0] rawFlags, filtFlags;
  ctrl_strobes_t        strobes;

  always_comb begin
    rawFlags             = '0;
    rawFlags[IDX_OV]     = pbatOv;
    rawFlags[IDX_UV]     = vbatUv;
    rawFlags[IDX_RAILUV] = pbatUv;
    rawFlags[IDX_SHORT]  = shortDet;
    rawFlags[IDX_CPF]    = ~cpOk;
    rawFlags[IDX_WARN]   = tempWarn;
    rawFlags[IDX_HOT]    = tempHot;
    rawFlags[IDX_COOL]   = tempCool;
  end

  supv_control uCtrl (
    .clk      (clk),
    .rstN     (rstN),
    .wdAccept (wdAccept),
    .hotFilt  (filtFlags[IDX_HOT]),
    .coolFilt (filtFlags[IDX_COOL]),
    .strobes  (strobes)
  );

  supv_datapath #(.DEB_LEN(DEB_LEN)) uData (
    .clk       (clk),
    .rstN      (rstN),
    .rawFlags  (rawFlags),
    .strobes   (strobes),
    .filtFlags (filtFlags),
    .bridgeEn  (bridgeEn),
    .diag1     (diag1),
    .diag2     (diag2),
    .diag3     (diag3),
    .cpOff     (cpOff),
    .regOff    (regOff),
    .drvOff    (drvOff),
    .serOff    (serOff),
    .resetReq  (resetReq)
  );
endmodule

// File: tb/sim_fault_supervisor.sv
`timescale 1ns/1ps
module sim_fault_supervisor;
  logic clk = 1'b0;
  logic rstN = 1'b0;
  logic wdAccept = 0, pbatOv = 0, vbatUv = 0, pbatUv = 0, shortDet = 0;
  logic cpOk = 1, tempWarn = 0, tempHot = 0, tempCool = 0;
  logic bridgeEn, diag1, diag2, diag3, cpOff, regOff, drvOff, serOff, resetReq;
  int checks = 0, fails = 0;
  bit finished = 0;

  always #2 clk = ~clk;  // 250 MHz

  fault_supervisor #(.DEB_LEN(4)) u0 (.*);

  task automatic check(string req, logic [7:0] got, logic [7:0] exp);
    checks++;
    if (got !== exp) begin
      fails++;
      $display("FAIL %s: got %0h expected %0h", req, got, exp);
    end
  endtask

  // advance n rising edges, then sample mid-cycle
  task automatic step(int n);
    repeat (n) @(posedge clk);
    #1;
  endtask

  task automatic pulseWd();
    @(negedge clk); wdAccept = 1;
    @(negedge clk); wdAccept = 0;
    step(1);
  endtask

  task automatic tReset();
    step(1);
    check("R11 outputs", {bridgeEn, diag1, diag2, diag3, cpOff, regOff, drvOff, resetReq}, 8'h00);
    check("R11 serOff", serOff, 0);
  endtask

  task automatic tArm();
    step(6);
    check("R11 no enable before trigger", bridgeEn, 0);
    pulseWd();
    check("R2 enable after trigger", bridgeEn, 1);
  endtask

  task automatic tDebounce();
    @(negedge clk); pbatUv = 1;
    step(3);
    check("R1 3 samples ignored", {bridgeEn, diag1, diag2}, 3'b100);
    @(negedge clk); pbatUv = 0;
    step(6);
    check("R1 glitch no effect", {bridgeEn, diag1, diag2}, 3'b100);
    @(negedge clk); pbatUv = 1;
    step(3);
    check("R1 not yet after 3", bridgeEn, 1);
    step(1);
    check("R1 acts after 4", bridgeEn, 0);
    check("R5 rail uv code", {diag1, diag2}, 2'b11);
    @(negedge clk); pbatUv = 0;
    step(6);
  endtask

  task automatic tCodes();
    check("R5 no fault code", {diag1, diag2}, 2'b00);
    @(negedge clk); shortDet = 1; step(6);
    check("R4 short code", {diag1, diag2}, 2'b10);
    check("R2 short blocks", bridgeEn, 0);
    @(negedge clk); pbatUv = 1; step(6);
    check("R4 short over rail uv", {diag1, diag2}, 2'b10);
    @(negedge clk); cpOk = 0; step(6);
    check("R3 cp fail over short", {diag1, diag2}, 2'b01);
    @(negedge clk); shortDet = 0; pbatUv = 0; cpOk = 1; vbatUv = 1; step(6);
    check("R3 vbat uv code", {diag1, diag2}, 2'b01);
    check("R2 vbat uv blocks", bridgeEn, 0);
    check("R10 cpOff low on uv", cpOff, 0);
    @(negedge clk); vbatUv = 0; pbatOv = 1; step(6);
    check("R3 ov code", {diag1, diag2}, 2'b01);
    check("R10 cpOff on ov", cpOff, 1);
    check("R2 ov blocks", bridgeEn, 0);
    @(negedge clk); pbatOv = 0; step(6);
    check("R10 cpOff released", cpOff, 0);
    check("R2 enable restored", bridgeEn, 1);
  endtask

  task automatic tWarn();
    @(negedge clk); tempWarn = 1; step(6);
    check("R6 warn on diag3", diag3, 1);
    check("R6 still enabled", {bridgeEn, resetReq, regOff}, 3'b100);
    @(negedge clk); tempWarn = 0; step(6);
    check("R6 warn cleared", diag3, 0);
  endtask

  task automatic tShutdown();
    @(negedge clk); tempHot = 1;
    step(4);
    check("R7 not before filter+1", resetReq, 0);
    step(1);
    check("R7 shutdown requests", {regOff, drvOff, serOff, resetReq, bridgeEn}, 5'b11110);
    check("R9 diag3 set", diag3, 1);
    pulseWd();
    @(negedge clk); tempHot = 0; step(8);
    check("R8 held without cool", resetReq, 1);
    @(negedge clk); tempCool = 1; step(7);
    check("R8 released on cool", {regOff, drvOff, serOff, resetReq}, 4'b0000);
    check("R9 latch survives wd in shutdown", diag3, 1);
    check("R7 trigger state cleared", bridgeEn, 0);
    @(negedge clk); tempCool = 0;
    pulseWd();
    check("R9 diag3 cleared by wd", diag3, 0);
    check("R2 enable after re-arm", bridgeEn, 1);
  endtask

  initial begin
    repeat (3) @(posedge clk);
    @(negedge clk); rstN = 1;
    tReset();
    tArm();
    tDebounce();
    tCodes();
    tWarn();
    tShutdown();
    if (!finished) begin
      finished = 1;
      $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
      $finish;
    end
  end

  initial begin
    #100000;
    if (!finished) begin
      finished = 1;
      checks++; fails++;
      $display("FAIL watchdog: got timeout expected completion");
      $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
      $finish;
    end
  end
endmodule